// File: doc/BRIEF.md
# Debug Event Unit

This unit sits beside the retire stage of a small processor core and turns the stream of completed instructions into debug events. For every retired instruction it compares the instruction pointer with two programmable breakpoint addresses, looks at the instruction-class tag for the two software breakpoint instruction kinds, and checks three independently enabled trace classes: single-step, call/return and branch. Traces are judged only on retired instructions, so the instruction that triggers a trace has already completed when the handler is requested.

When an event is detected, the unit pulses a request, presents a 3-bit cause code and raises an issue stall toward the core. The stall and the cause stay put until the handler software reports completion on a done strobe. The core then carries on with the next instruction. While a handler runs, detection is disarmed, so the handler's own instructions raise nothing.

Breakpoint addresses, their valid bits and the trace enables are loaded through a small write port with a 2-bit register select.

Top module: `dbg_trace_unit`

## Requirements
- R1: After reset dbg_req and issue_stall are 0, dbg_cause is 0, both breakpoints are invalid and all trace enables are off.
- R2: A write with cfg_wr_addr 0 or 1 loads breakpoint 0 or 1 with the 32-bit cfg_wr_data and marks it valid. Select 2 loads the trace enables from data bit 0 (step), bit 1 (call/return) and bit 2 (branch). Select 3 invalidates breakpoint 0 when data bit 0 is 1 and breakpoint 1 when data bit 1 is 1.
- R3: A retired instruction whose pointer equals a valid breakpoint raises an event with cause 1 (breakpoint 0) or 2 (breakpoint 1). When both match, cause 1 is reported.
- R4: An invalid breakpoint never matches, including at pointer value zero.
- R5: A retired instruction with class 4 or class 5 (software breakpoints) raises cause 3 whatever the trace enables are.
- R6: The class codes are 0 plain, 1 call, 2 return and 3 branch. With call/return trace enabled, class 1 or 2 raises cause 5. With branch trace enabled, class 3 raises cause 6. With step enabled, any other retired instruction raises cause 4. A class-specific trace takes precedence over step, and a disabled class raises nothing.
- R7: When a breakpoint or software breakpoint and a trace apply to the same instruction, only the breakpoint cause (1, 2 or 3) is reported.
- R8: An event on a retire sampled at clock edge k gives dbg_req high for exactly the cycle after edge k. issue_stall rises and dbg_cause takes the code at the same edge. Code 0 means no event.
- R9: issue_stall stays high and dbg_cause stays constant until hdl_done is sampled high. At that edge issue_stall falls and dbg_cause returns to 0.
- R10: Retires sampled while issue_stall is high, including one in the same cycle as hdl_done, raise no event. hdl_done while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_ip | input | 32 | Pointer of the retiring instruction |
| retire_cls | input | 3 | Class tag of the retiring instruction |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Configuration register select |
| cfg_wr_data | input | 32 | Configuration write data |
| hdl_done | input | 1 | Handler completion strobe |
| dbg_req | output | 1 | One-cycle debug-event request |
| dbg_cause | output | 3 | Cause code of the pending event |
| issue_stall | output | 1 | Holds further issue while a handler runs |

## Verification
The bench stresses the priority corners. These include both breakpoints holding the same address, a breakpoint or software breakpoint landing on an instruction that is also traced, and a call retiring with both step and call/return enabled. A wrong priority order shows up there as the wrong cause code. A breakpoint is loaded with zero and then invalidated, so a design that ignores the valid bit fires on pointer zero. Retires are issued while the stall is held and in the very cycle of the done strobe, so a unit that re-arms too early raises a second request or changes its cause. A done strobe is also sent while idle, where a broken unit would corrupt its state.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int IP_W    = 32;
    localparam int NUM_BP  = 2;
    localparam int CAUSE_W = 3;
    localparam int CLS_W   = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_HWBP0   = 3'd1,
        CAUSE_HWBP1   = 3'd2,
        CAUSE_SWBRK   = 3'd3,
        CAUSE_STEP    = 3'd4,
        CAUSE_CALLRET = 3'd5,
        CAUSE_BRANCH  = 3'd6
    } cause_e;

    typedef enum logic [CLS_W-1:0] {
        ICLS_PLAIN   = 3'd0,
        ICLS_CALL    = 3'd1,
        ICLS_RET     = 3'd2,
        ICLS_BRANCH  = 3'd3,
        ICLS_SWBRK_A = 3'd4,
        ICLS_SWBRK_B = 3'd5
    } icls_e;

    localparam logic [SEL_W-1:0] CFG_BP0 = 2'd0;
    localparam logic [SEL_W-1:0] CFG_BP1 = 2'd1;
    localparam logic [SEL_W-1:0] CFG_TRC = 2'd2;
    localparam logic [SEL_W-1:0] CFG_CLR = 2'd3;

    // bit 0 step, bit 1 call/return, bit 2 branch
    typedef struct packed {
        logic branch;
        logic callret;
        logic step;
    } trc_en_t;

    typedef struct packed {
        logic   hit;
        cause_e cause;
    } dbg_evt_t;

    function automatic logic is_swbrk(icls_e c);
        return (c == ICLS_SWBRK_A) || (c == ICLS_SWBRK_B);
    endfunction

    function automatic logic is_callret(icls_e c);
        return (c == ICLS_CALL) || (c == ICLS_RET);
    endfunction

    function automatic cause_e bp_cause(int idx);
        return (idx == 0) ? CAUSE_HWBP0 : CAUSE_HWBP1;
    endfunction

endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbg_pkg::*;
#(
    parameter int W  = IP_W,
    parameter int NB = NUM_BP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     bp_addr [NB],
    output logic [NB-1:0]    bp_vld,
    output trc_en_t          trc_en
);

    for (genvar g = 0; g < NB; g++) begin : g_bp
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                bp_addr[g] <= '0;
                bp_vld[g]  <= 1'b0;
            end else if (wr_en && wr_sel == MY_SEL) begin
                bp_addr[g] <= wr_data;
                bp_vld[g]  <= 1'b1;
            end else if (wr_en && wr_sel == CFG_CLR && wr_data[g]) begin
                bp_vld[g]  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trc_en <= '0;
        end else if (wr_en && wr_sel == CFG_TRC) begin
            trc_en <= trc_en_t'(wr_data[2:0]);
        end
    end

endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
    import dbg_pkg::*;
#(
    parameter int W  = IP_W,
    parameter int NB = NUM_BP
) (
    input  logic [W-1:0]  ip,
    input  logic [W-1:0]  bp_addr [NB],
    input  logic [NB-1:0] bp_vld,
    output logic [NB-1:0] hit
);

    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign hit[g] = bp_vld[g] && (ip == bp_addr[g]);
    end

endmodule

// File: rtl/dbg_event_sel.sv
module dbg_event_sel
    import dbg_pkg::*;
#(
    parameter int NB = NUM_BP
) (
    input  logic             retire_vld,
    input  logic [CLS_W-1:0] retire_cls,
    input  logic [NB-1:0]    bp_hit,
    input  trc_en_t          trc_en,
    output dbg_evt_t         evt
);

    icls_e cls;
    assign cls = icls_e'(retire_cls);

    always_comb begin
        evt = '{hit: 1'b0, cause: CAUSE_NONE};
        if (retire_vld) begin
            // lowest priority first; later assignments override
            if (trc_en.step) begin
                evt = '{hit: 1'b1, cause: CAUSE_STEP};
            end
            if (trc_en.branch && cls == ICLS_BRANCH) begin
                evt = '{hit: 1'b1, cause: CAUSE_BRANCH};
            end
            if (trc_en.callret && is_callret(cls)) begin
                evt = '{hit: 1'b1, cause: CAUSE_CALLRET};
            end
            if (is_swbrk(cls)) begin
                evt = '{hit: 1'b1, cause: CAUSE_SWBRK};
            end
            for (int i = NB - 1; i >= 0; i--) begin
                if (bp_hit[i]) begin
                    evt = '{hit: 1'b1, cause: bp_cause(i)};
                end
            end
        end
    end

endmodule

// File: rtl/dbg_handler_ctl.sv
module dbg_handler_ctl
    import dbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dbg_evt_t evt,
    input  logic     hdl_done,
    output logic     req,
    output logic     busy,
    output cause_e   cause
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            busy  <= 1'b0;
            cause <= CAUSE_NONE;
        end else begin
            req <= 1'b0;
            if (busy) begin
                if (hdl_done) begin
                    busy  <= 1'b0;
                    cause <= CAUSE_NONE;
                end
            end else if (evt.hit) begin
                req   <= 1'b1;
                busy  <= 1'b1;
                cause <= evt.cause;
            end
        end
    end

endmodule

// File: rtl/dbg_trace_unit.sv
module dbg_trace_unit
    import dbg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               retire_vld,
    input  logic [IP_W-1:0]    retire_ip,
    input  logic [CLS_W-1:0]   retire_cls,
    input  logic               cfg_wr_en,
    input  logic [SEL_W-1:0]   cfg_wr_addr,
    input  logic [IP_W-1:0]    cfg_wr_data,
    input  logic               hdl_done,
    output logic               dbg_req,
    output logic [CAUSE_W-1:0] dbg_cause,
    output logic               issue_stall
);

    logic [IP_W-1:0]   bp_addr [NUM_BP];
    logic [NUM_BP-1:0] bp_vld;
    logic [NUM_BP-1:0] bp_hit;
    trc_en_t           trc_en;
    dbg_evt_t          evt;
    cause_e            cause_q;

    dbg_cfg_regs #(.W(IP_W), .NB(NUM_BP)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .bp_addr (bp_addr),
        .bp_vld  (bp_vld),
        .trc_en  (trc_en)
    );

    dbg_bp_match #(.W(IP_W), .NB(NUM_BP)) u_match (
        .ip      (retire_ip),
        .bp_addr (bp_addr),
        .bp_vld  (bp_vld),
        .hit     (bp_hit)
    );

    dbg_event_sel #(.NB(NUM_BP)) u_sel (
        .retire_vld (retire_vld),
        .retire_cls (retire_cls),
        .bp_hit     (bp_hit),
        .trc_en     (trc_en),
        .evt        (evt)
    );

    dbg_handler_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .hdl_done (hdl_done),
        .req      (dbg_req),
        .busy     (issue_stall),
        .cause    (cause_q)
    );

    assign dbg_cause = cause_q;

endmodule

// File: rtl/dbg_trace_unit_chk.sv
module dbg_trace_unit_chk
    import dbg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               retire_vld,
    input logic [CLS_W-1:0]   retire_cls,
    input logic               hdl_done,
    input logic               dbg_req,
    input logic [CAUSE_W-1:0] dbg_cause,
    input logic               issue_stall
);

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        dbg_req |=> !dbg_req); // R8

    AST_REQ_WITH_STALL: assert property (@(posedge clk) disable iff (rst)
        dbg_req |-> (issue_stall && dbg_cause != 3'd0)); // R8

    AST_REQ_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        dbg_req |-> !$past(issue_stall)); // R10

    AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !issue_stall |-> dbg_cause == 3'd0); // R9

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (issue_stall && !hdl_done) |=> (issue_stall && $stable(dbg_cause))); // R9

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (issue_stall && hdl_done) |=> !issue_stall); // R9

    AST_SWBRK_FIRES: assert property (@(posedge clk) disable iff (rst)
        (!issue_stall && retire_vld && (retire_cls == 3'd4 || retire_cls == 3'd5))
        |=> (dbg_req && dbg_cause inside {3'd1, 3'd2, 3'd3})); // R5

endmodule

bind dbg_trace_unit dbg_trace_unit_chk u_chk (.*);

// File: tb/dbg_trace_unit_tb.sv
module dbg_trace_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        retire_vld;
    logic [31:0] retire_ip;
    logic [2:0]  retire_cls;
    logic        cfg_wr_en;
    logic [1:0]  cfg_wr_addr;
    logic [31:0] cfg_wr_data;
    logic        hdl_done;
    logic        dbg_req;
    logic [2:0]  dbg_cause;
    logic        issue_stall;

    dbg_trace_unit u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string tag      = "R1";

    // reference model state
    logic [31:0] m_bp [2];
    bit          m_bv [2];
    bit [2:0]    m_ten;
    bit          m_busy;
    bit          m_req;
    int          m_cause;

    task automatic model_reset();
        m_bp[0] = 0; m_bp[1] = 0; m_bv[0] = 0; m_bv[1] = 0;
        m_ten = 0; m_busy = 0; m_req = 0; m_cause = 0;
    endtask

    task automatic model_edge();
        int c;
        m_req = 0;
        if (m_busy) begin
            if (hdl_done) begin
                m_busy = 0;
                m_cause = 0;
            end
        end else if (retire_vld) begin
            c = 0;
            if (m_bv[0] && retire_ip == m_bp[0]) c = 1;
            else if (m_bv[1] && retire_ip == m_bp[1]) c = 2;
            else if (retire_cls == 4 || retire_cls == 5) c = 3;
            else if ((retire_cls == 1 || retire_cls == 2) && m_ten[1]) c = 5;
            else if (retire_cls == 3 && m_ten[2]) c = 6;
            else if (m_ten[0]) c = 4;
            if (c != 0) begin
                m_req = 1;
                m_busy = 1;
                m_cause = c;
            end
        end
        if (cfg_wr_en) begin
            case (cfg_wr_addr)
                2'd0: begin m_bp[0] = cfg_wr_data; m_bv[0] = 1; end
                2'd1: begin m_bp[1] = cfg_wr_data; m_bv[1] = 1; end
                2'd2: m_ten = cfg_wr_data[2:0];
                default: begin
                    if (cfg_wr_data[0]) m_bv[0] = 0;
                    if (cfg_wr_data[1]) m_bv[1] = 0;
                end
            endcase
        end
    endtask

    task automatic compare();
        n_checks++;
        if (dbg_req !== m_req || issue_stall !== m_busy || dbg_cause !== 3'(m_cause)) begin
            n_fails++;
            $display("FAIL %s: req/stall/cause = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     tag, dbg_req, issue_stall, dbg_cause, m_req, m_busy, m_cause);
        end
    endtask

    // one clock: inputs held from a falling edge, model steps at the rising edge,
    // outputs compared at the following falling edge
    task automatic cyc(bit v, logic [31:0] ip, logic [2:0] cls,
                       bit we, logic [1:0] wa, logic [31:0] wd, bit dn);
        retire_vld = v; retire_ip = ip; retire_cls = cls;
        cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd; hdl_done = dn;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic rt(logic [31:0] ip, logic [2:0] cls);
        cyc(1, ip, cls, 0, 0, 0, 0);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cyc(0, 0, 0, 1, a, d, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic done();
        cyc(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst = 1;
        retire_vld = 0; retire_ip = 0; retire_cls = 0;
        cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_data = 0; hdl_done = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        tag = "R1"; compare();

        // R4: nothing valid, pointer zero and others never hit
        tag = "R4"; rt(32'h0, 0); rt(32'h1000, 0); rt(32'h0, 3);

        // R10: done while idle has no effect
        tag = "R10"; done(); idle(1);

        // R2/R3/R8/R9: breakpoint 0
        tag = "R2"; wr(0, 32'h1000);
        tag = "R3"; rt(32'h1000, 0);
        tag = "R9"; idle(3);
        tag = "R10"; rt(32'h1000, 4); rt(32'h2000, 3);
        tag = "R9"; done(); idle(1);

        // breakpoint 1
        tag = "R2"; wr(1, 32'h2000);
        tag = "R3"; rt(32'h2000, 1); idle(1); done();
        // both match the same address
        wr(0, 32'h3000); wr(1, 32'h3000);
        tag = "R3"; rt(32'h3000, 0); done();

        // invalidate breakpoint 0 only
        tag = "R2"; wr(3, 32'h1);
        tag = "R4"; rt(32'h3000, 0); done();
        // zero address loaded then invalidated
        wr(0, 32'h0); wr(3, 32'h3);
        tag = "R4"; rt(32'h0, 0); rt(32'h3000, 0); idle(1);

        // software breakpoints
        tag = "R5"; rt(32'h40, 4); done(); rt(32'h44, 5); done();
        wr(2, 32'h7);
        tag = "R5"; rt(32'h48, 5); done();

        // traces
        tag = "R6"; wr(2, 32'h4);
        rt(32'h50, 1); rt(32'h54, 0); rt(32'h58, 3); done();
        wr(2, 32'h2);
        rt(32'h5c, 3); rt(32'h60, 1); done(); rt(32'h64, 2); done();
        wr(2, 32'h1);
        rt(32'h68, 0); done(); rt(32'h6c, 3); done();
        wr(2, 32'h7);
        rt(32'h70, 1); done(); rt(32'h74, 3); done(); rt(32'h78, 0); done();
        wr(2, 32'h0);
        rt(32'h7c, 1); rt(32'h80, 3); rt(32'h84, 0);

        // breakpoints beat traces
        wr(2, 32'h7); wr(1, 32'h90);
        tag = "R7"; rt(32'h90, 3); done(); rt(32'h94, 4); done(); rt(32'h90, 1); done();

        // R10: retire in the same cycle as the done strobe is ignored
        tag = "R10"; rt(32'h98, 0);
        cyc(1, 32'h90, 0, 0, 0, 0, 1);
        rt(32'h9c, 0); done();

        // R8: back-to-back events after release
        tag = "R8"; rt(32'hA0, 3); done(); rt(32'hA4, 0); done(); idle(2);

        finish_run();
    end

endmodule